// File: doc/BRIEF.md
# Event-stepped two-wire bus master

This block is a byte-level master engine for a two-wire serial bus, driven one bus event at a time. Software writes an 8-bit control register and an 8-bit data register. It reads the control register back, along with the data register and an 8-bit status register. Each request produces one bus step: a START, a repeated START, one byte with its acknowledge slot, or a STOP. When the step is done, the engine raises an event flag and posts a numeric status code that names the outcome. It then holds SCL low until software clears the flag.

Bit timing comes from an external `tick` strobe supplied by a shared divider. Each bit takes four ticks. Both bus lines are open-drain: an output high means "pull the line low". Two force inputs let software pull either line low directly. With them it can clock out recovery pulses and build a STOP by hand on a stuck bus.

Top module: `tw_master`

## Requirements
- R1: After reset the control register reads 0x00, the data register reads 0x00, the status reads 0xF8 and neither line is pulled low.
- R2: With bus enable (control bit 6) set and start request (bit 5) set on an idle bus, a START is made. The status becomes 0x08, the event flag (bit 3) is set and the start request bit reads back 0.
- R3: A start request made while the bus is owned produces a repeated START with status 0x10.
- R4: The first byte after a START goes out MSB first from the data register (7-bit target in bits 7:1, bit 0 = 1 for read). The status becomes 0x18 or 0x20 for a write address that is ACKed or NACKed, and 0x40 or 0x48 for a read address that is ACKed or NACKed.
- R5: In a write, each data byte goes out MSB first. The status becomes 0x28 when the target ACKs it and 0x30 when it NACKs it.
- R6: In a read, the received byte lands in the data register. The master ACKs it and reports 0x50 when assert-ACK (control bit 2) was set at the step's start; otherwise it NACKs it and reports 0x58.
- R7: While the event flag is set, SCL stays pulled low and no further step starts. The flag is cleared only by a control write with bit 3 at 0. Writing bit 3 as 1 neither clears it nor, on an idle bus, sets it.
- R8: A stop request (bit 4) on an owned bus makes a STOP. The stop bit then reads 0, the status returns to 0xF8, the event flag stays clear and both lines are released.
- R9: Asserting `scl_force` or `sda_force` pulls the matching line low from the next clock on, whatever the engine is doing.
- R10: With bus enable clear, a pending start request is held in the register but no bus activity occurs and the status stays 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Quarter-bit timing strobe from the divider |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects data |
| reg_wdata | input | 8 | Write data |
| ctl_rd | output | 8 | Control register readback |
| data_rd | output | 8 | Data register readback |
| status_rd | output | 8 | Status code |
| sda_in | input | 1 | Sensed SDA line level |
| scl_force | input | 1 | Software pull-low of SCL |
| sda_force | input | 1 | Software pull-low of SDA |
| scl_lo | output | 1 | Pull SCL low |
| sda_lo | output | 1 | Pull SDA low |

## Verification
Register writes show in the readback one cycle after the write edge. A forced line shows on its output one cycle after the force is asserted. Status and event flag appear together on the cycle after the last quarter-tick of a step, so a byte's result comes about 36 ticks after the flag-clearing write. The bench therefore polls the event flag, or the stop bit for a STOP, at falling clock edges and compares status, data and the captured bus byte only once that indicator has moved. Hold behaviour is checked after a wait of a hundred cycles with the flag still set.

// File: rtl/tw_pkg.sv
// Shared types and codes for the two-wire master.
// Assumes an 8-bit control/status map; positions are decoded by software.
package tw_pkg;

    typedef enum logic [1:0] {OP_START, OP_STOP, OP_BYTE} tw_op_e;

    localparam int CB_ENA = 6;
    localparam int CB_STA = 5;
    localparam int CB_STP = 4;
    localparam int CB_FLG = 3;
    localparam int CB_ACK = 2;

    localparam logic [7:0] SC_IDLE    = 8'hF8;
    localparam logic [7:0] SC_START   = 8'h08;
    localparam logic [7:0] SC_RSTART  = 8'h10;
    localparam logic [7:0] SC_WA_ACK  = 8'h18;
    localparam logic [7:0] SC_WA_NACK = 8'h20;
    localparam logic [7:0] SC_WD_ACK  = 8'h28;
    localparam logic [7:0] SC_WD_NACK = 8'h30;
    localparam logic [7:0] SC_RA_ACK  = 8'h40;
    localparam logic [7:0] SC_RA_NACK = 8'h48;
    localparam logic [7:0] SC_RD_ACK  = 8'h50;
    localparam logic [7:0] SC_RD_NACK = 8'h58;

    // Status after a byte step: address or data, direction, acknowledge outcome.
    function automatic logic [7:0] byte_code(input logic is_addr, input logic rd,
                                             input logic tgt_ack, input logic own_ack);
        if (is_addr)
            return rd ? (tgt_ack ? SC_RA_ACK : SC_RA_NACK) : (tgt_ack ? SC_WA_ACK : SC_WA_NACK);
        else
            return rd ? (own_ack ? SC_RD_ACK : SC_RD_NACK) : (tgt_ack ? SC_WD_ACK : SC_WD_NACK);
    endfunction

endpackage

// File: rtl/tw_seq.sv
// Quarter-tick bus sequencer: runs one START, STOP or byte+ack step per go.
// Assumes go is only raised while not busy; line outputs mean "pull low".
module tw_seq
    import tw_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          go,
    input  tw_op_e        op,
    input  logic [DW-1:0] tx_byte,
    input  logic          rx_mode,
    input  logic          ack_send,
    input  logic          sda_in,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rx_byte,
    output logic          ack_seen,
    output logic          scl_lo,
    output logic          sda_lo
);
    localparam int CW = $clog2(DW + 2);

    tw_op_e        op_q;
    logic [1:0]    phase;
    logic [CW-1:0] bitn;
    logic [DW-1:0] txsh;
    logic          rx_q, ack_q;
    logic          last;

    assign last = (bitn == CW'(DW));

    // Step state machine: latch the request, then walk quarter phases on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_START; phase <= '0; bitn <= '0; txsh <= '0;
            rx_q <= 1'b0; ack_q <= 1'b0; busy <= 1'b0; done <= 1'b0;
            rx_byte <= '0; ack_seen <= 1'b0; scl_lo <= 1'b0; sda_lo <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                busy <= 1'b1; op_q <= op; phase <= '0; bitn <= '0;
                txsh <= tx_byte; rx_q <= rx_mode; ack_q <= ack_send;
            end else if (busy && tick) begin
                phase <= phase + 2'd1;
                unique case (op_q)
                    OP_START: begin
                        unique case (phase)
                            2'd0: begin scl_lo <= 1'b1; sda_lo <= 1'b0; end
                            2'd1: scl_lo <= 1'b0;
                            2'd2: sda_lo <= 1'b1;
                            default: begin scl_lo <= 1'b1; busy <= 1'b0; done <= 1'b1; end
                        endcase
                    end
                    OP_STOP: begin
                        unique case (phase)
                            2'd0: begin scl_lo <= 1'b1; sda_lo <= 1'b1; end
                            2'd1: scl_lo <= 1'b0;
                            2'd2: sda_lo <= 1'b0;
                            default: begin busy <= 1'b0; done <= 1'b1; end
                        endcase
                    end
                    default: begin
                        unique case (phase)
                            2'd0: begin
                                scl_lo <= 1'b1;
                                sda_lo <= last ? (rx_q & ack_q) : (!rx_q & !txsh[DW-1]);
                            end
                            2'd1: scl_lo <= 1'b0;
                            2'd2: begin
                                if (last) ack_seen <= !sda_in;
                                else      rx_byte  <= {rx_byte[DW-2:0], sda_in};
                            end
                            default: begin
                                scl_lo <= 1'b1;
                                txsh   <= {txsh[DW-2:0], 1'b0};
                                if (last) begin busy <= 1'b0; done <= 1'b1; end
                                else      bitn <= bitn + 1'b1;
                            end
                        endcase
                    end
                endcase
            end
        end
    end

    a_r4_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> bitn <= CW'(DW));
    a_r8_stop_frees_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_STOP) |-> (!scl_lo && !sda_lo));
    a_r2_start_leaves_both_low: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_START) |-> (scl_lo && sda_lo));
endmodule

// File: rtl/tw_pad.sv
// Line output stage: merges engine pull-lows with software forces and registers them.
// Assumes forces are already synchronous to clk.
module tw_pad #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] eng_lo,
    input  logic [LANES-1:0] force_lo,
    output logic [LANES-1:0] line_lo
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Register one lane: a force overrides the engine.
        always_ff @(posedge clk) begin
            if (!rst_n) line_lo[g] <= 1'b0;
            else        line_lo[g] <= eng_lo[g] | force_lo[g];
        end

        a_r9_force_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
            force_lo[g] |=> line_lo[g]);
    end
endmodule

// File: rtl/tw_master.sv
// Event-stepped two-wire master: register file, step dispatch and status coding.
// Assumes single-master bus, no clock stretching; tick paces quarter bits.
module tw_master
    import tw_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          reg_we,
    input  logic          reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [7:0]    ctl_rd,
    output logic [DW-1:0] data_rd,
    output logic [7:0]    status_rd,
    input  logic          sda_in,
    input  logic          scl_force,
    input  logic          sda_force,
    output logic          scl_lo,
    output logic          sda_lo
);
    logic          ena, sta, stp, flg, aak;
    logic [DW-1:0] data_q;
    logic [7:0]    stat_q;
    logic          active, first, rd_q, cur_aak;
    tw_op_e        cur_op, go_op;
    logic          may_go, go;
    logic          busy, done, ack_seen, eng_scl, eng_sda;
    logic [DW-1:0] rx_byte;
    logic [1:0]    lines;

    // Dispatch: pick the next step once enabled, idle and acknowledged.
    always_comb begin
        may_go = ena && !busy && !done && !flg;
        go     = 1'b0;
        go_op  = OP_BYTE;
        if (may_go) begin
            if (sta)                 begin go = 1'b1; go_op = OP_START; end
            else if (stp && active)  begin go = 1'b1; go_op = OP_STOP;  end
            else if (!stp && active) begin go = 1'b1; go_op = OP_BYTE;  end
        end
    end

    // Register file and step bookkeeping; hardware updates follow software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena <= 1'b0; sta <= 1'b0; stp <= 1'b0; flg <= 1'b0; aak <= 1'b0;
            data_q <= '0; stat_q <= SC_IDLE; active <= 1'b0; first <= 1'b0;
            rd_q <= 1'b0; cur_aak <= 1'b0; cur_op <= OP_START;
        end else begin
            if (reg_we && !reg_sel) begin
                ena <= reg_wdata[CB_ENA]; sta <= reg_wdata[CB_STA];
                stp <= reg_wdata[CB_STP]; aak <= reg_wdata[CB_ACK];
                if (!reg_wdata[CB_FLG]) flg <= 1'b0;
            end
            if (reg_we && reg_sel) data_q <= reg_wdata;
            if (may_go && !sta && stp && !active) stp <= 1'b0;
            if (go) begin
                cur_op  <= go_op;
                cur_aak <= aak;
                if (go_op == OP_BYTE && first) rd_q <= data_q[0];
            end
            if (done) begin
                unique case (cur_op)
                    OP_START: begin
                        sta <= 1'b0; flg <= 1'b1; first <= 1'b1; active <= 1'b1;
                        stat_q <= active ? SC_RSTART : SC_START;
                    end
                    OP_STOP: begin
                        stp <= 1'b0; active <= 1'b0; first <= 1'b0; stat_q <= SC_IDLE;
                    end
                    default: begin
                        flg    <= 1'b1;
                        first  <= 1'b0;
                        stat_q <= byte_code(first, rd_q, ack_seen, cur_aak);
                        if (rd_q && !first) data_q <= rx_byte;
                    end
                endcase
            end
        end
    end

    tw_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .op(go_op),
        .tx_byte(data_q), .rx_mode(rd_q && !first), .ack_send(aak),
        .sda_in(sda_in), .busy(busy), .done(done), .rx_byte(rx_byte),
        .ack_seen(ack_seen), .scl_lo(eng_scl), .sda_lo(eng_sda)
    );

    tw_pad #(.LANES(2)) u_pad (
        .clk(clk), .rst_n(rst_n), .eng_lo({eng_sda, eng_scl}),
        .force_lo({sda_force, scl_force}), .line_lo(lines)
    );

    assign scl_lo    = lines[0];
    assign sda_lo    = lines[1];
    assign ctl_rd    = {1'b0, ena, sta, stp, flg, aak, 2'b00};
    assign data_rd   = data_q;
    assign status_rd = stat_q;

    a_r7_hold_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        flg |-> (eng_scl && !busy));
    a_r8_stop_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> (!flg && stat_q == SC_IDLE));
    a_r2_start_req_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flg) && (stat_q == SC_START || stat_q == SC_RSTART)) |-> !sta);
    a_r10_disabled_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ena && !busy) |=> !busy);
endmodule

// File: tb/tw_master_bench.sv
module tw_master_bench;
    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic       reg_we = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       scl_force = 1'b0, sda_force = 1'b0;
    wire  [7:0] ctl_rd, data_rd, status_rd;
    wire        scl_lo, sda_lo;
    logic       slv_lo = 1'b0;
    wire        sda_line = !sda_lo && !slv_lo;
    wire        scl_line = !scl_lo;

    tw_master u_tw_master (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctl_rd(ctl_rd), .data_rd(data_rd), .status_rd(status_rd),
        .sda_in(sda_line), .scl_force(scl_force), .sda_force(sda_force),
        .scl_lo(scl_lo), .sda_lo(sda_lo)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    initial forever begin
        repeat (3) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    end

    // Target model on the wired lines.
    logic       prev_scl = 1'b1, prev_sda = 1'b1;
    int         bits = 0, midx = 0, bidx = 0, nack_at = 99;
    bit         first = 0, rd = 0, quiet = 1;
    logic [7:0] rxb = 8'h00, cap = 8'h00;
    logic [7:0] mem [4];

    always @(scl_line or sda_line) begin
        if (scl_line && prev_scl && prev_sda && !sda_line) begin
            bits = 0; first = 1; quiet = 0; midx = 0; bidx = 0; slv_lo = 1'b0;
        end else if (scl_line && !prev_scl && !quiet) begin
            if (bits < 8) begin
                rxb = {rxb[6:0], sda_line}; bits++;
            end else begin
                if (rd && !first) begin
                    if (sda_line) quiet = 1;
                    midx++;
                end else begin
                    cap = rxb;
                    if (first) rd = rxb[0];
                    if (bidx == nack_at) quiet = 1;
                end
                first = 0; bidx++; bits = 0;
            end
        end else if (!scl_line && prev_scl) begin
            if (quiet)                slv_lo = 1'b0;
            else if (bits == 8)       slv_lo = !(rd && !first) && (bidx != nack_at);
            else if (rd && !first)    slv_lo = !mem[midx % 4][7 - bits];
            else                      slv_lo = 1'b0;
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    task automatic wr(bit sel, logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_flag(string req);
        int k = 0;
        while (!ctl_rd[3] && k < 5000) begin @(negedge clk); k++; end
        if (k >= 5000) check({req, " event flag timeout"}, 8'h00, 8'h01);
    endtask

    task automatic do_start(bit rep);
        wr(0, 8'h60);
        wait_flag(rep ? "R3" : "R2");
        check(rep ? "R3 repeated start status" : "R2 start status", status_rd, rep ? 8'h10 : 8'h08);
        check("R2 start bit cleared, flag set", ctl_rd, 8'h48);
    endtask

    task automatic do_addr(logic [6:0] a, bit r, bit ack);
        wr(1, {a, r});
        wr(0, 8'h40);
        wait_flag("R4");
        check("R4 address status", status_rd, r ? (ack ? 8'h40 : 8'h48) : (ack ? 8'h18 : 8'h20));
        check("R4 address bits on bus", cap, {a, r});
    endtask

    task automatic do_wbyte(logic [7:0] d, bit ack);
        wr(1, d);
        wr(0, 8'h40);
        wait_flag("R5");
        check("R5 write data status", status_rd, ack ? 8'h28 : 8'h30);
        check("R5 data bits on bus", cap, d);
    endtask

    task automatic do_rbyte(logic [7:0] exp, bit ack);
        wr(0, ack ? 8'h44 : 8'h40);
        wait_flag("R6");
        check("R6 read status", status_rd, ack ? 8'h50 : 8'h58);
        check("R6 received byte", data_rd, exp);
    endtask

    task automatic do_stop();
        int k = 0;
        wr(0, 8'h50);
        while (ctl_rd[4] && k < 5000) begin @(negedge clk); k++; end
        repeat (2) @(negedge clk);
        check("R8 status after stop", status_rd, 8'hF8);
        check("R8 control after stop", ctl_rd, 8'h40);
        check("R8 lines released", {6'd0, scl_lo, sda_lo}, 8'h00);
    endtask

    task automatic rnd_xfer();
        logic [6:0] a = 7'($urandom);
        bit r = 1'($urandom);
        int len = 1 + int'($urandom % 3);
        for (int i = 0; i < 4; i++) mem[i] = 8'($urandom);
        nack_at = ($urandom % 4 == 0) ? (r ? 0 : int'($urandom % (len + 1))) : 99;
        do_start(0);
        do_addr(a, r, nack_at != 0);
        if (nack_at != 0) begin
            for (int i = 1; i <= len; i++) begin
                if (r) do_rbyte(mem[i - 1], i != len);
                else   do_wbyte(8'($urandom), nack_at != i);
                if (nack_at == i) break;
            end
        end
        do_stop();
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 control reset", ctl_rd, 8'h00);
        check("R1 data reset", data_rd, 8'h00);
        check("R1 status reset", status_rd, 8'hF8);
        check("R1 lines released", {6'd0, scl_lo, sda_lo}, 8'h00);

        // R10 start request with enable low
        wr(0, 8'h20);
        repeat (80) @(negedge clk);
        check("R10 status stays idle", status_rd, 8'hF8);
        check("R10 request held", ctl_rd, 8'h20);
        check("R10 no line activity", {6'd0, scl_lo, sda_lo}, 8'h00);
        wr(0, 8'h00);

        // R7 writing flag as 1 on idle bus does not set it
        wr(0, 8'h48);
        check("R7 flag not set by write", ctl_rd, 8'h40);

        // Write, hold, repeated start, read
        nack_at = 99;
        mem[0] = 8'h5A; mem[1] = 8'h81;
        do_start(0);
        do_addr(7'h2A, 0, 1);
        do_wbyte(8'hC3, 1);
        repeat (100) @(negedge clk);
        check("R7 scl held low", {7'd0, scl_lo}, 8'h01);
        check("R7 status held", status_rd, 8'h28);
        wr(0, 8'h48);
        repeat (100) @(negedge clk);
        check("R7 flag kept by writing 1", ctl_rd, 8'h48);
        check("R7 no step while flag set", status_rd, 8'h28);
        do_start(1);
        do_addr(7'h2A, 1, 1);
        do_rbyte(8'h5A, 1);
        do_rbyte(8'h81, 0);
        do_stop();

        // NACK corner cases
        nack_at = 0;
        do_start(0); do_addr(7'h11, 0, 0); do_stop();
        do_start(0); do_addr(7'h12, 1, 0); do_stop();
        nack_at = 2;
        do_start(0); do_addr(7'h13, 0, 1); do_wbyte(8'hFF, 1); do_wbyte(8'h00, 0); do_stop();

        // R9 line forces
        @(negedge clk); scl_force = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 scl forced low", {7'd0, scl_lo}, 8'h01);
        sda_force = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 sda forced low", {7'd0, sda_lo}, 8'h01);
        scl_force = 1'b0;
        repeat (2) @(negedge clk);
        sda_force = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 lines free after forces", {6'd0, scl_lo, sda_lo}, 8'h00);
        check("R9 engine status untouched", status_rd, 8'hF8);

        for (int t = 0; t < 25; t++) rnd_xfer();

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule